// File: doc/BRIEF.md
# Section Address Translation Unit

This block turns 32-bit virtual addresses into physical addresses. Memory is split into 1 MiB sections, and a single-level table of section descriptors in memory describes them. The block holds three settings: a table base, a translation enable and a 16-domain access control word. For each accepted request it checks a small fully associative cache of recent descriptors. On a miss it reads one descriptor through a simple memory read port. It then checks the descriptor's domain against the access control word. The result is either a physical address with cacheable/bufferable attributes, or an abort with a packed fault status byte.

A request is offered with a valid/ready handshake. A hit, or a request made while translation is off, produces a one-cycle response pulse in the cycle after acceptance. A miss drops `req_ready` until the descriptor arrives, and the response follows in the cycle after `mem_rvalid`. The descriptor cache has an invalidate-all command. Software must issue it after editing any table entry.

Top module: `sect_xlate_unit`

## Requirements
- R1: With the enable bit clear, an accepted request responds in the next cycle with `rsp_paddr` equal to the virtual address, cache, buffer and abort all 0, and no memory read.
- R2: On a miss, `mem_req` rises with `mem_addr` = {base[31:14], vaddr[31:20], 2'b00}. Both stay stable until `mem_rvalid`, and exactly one read is made.
- R3: Settings are written with `cfg_we` and `cfg_sel` (0 = table base, 1 = domain word, 2 = enable in bit 0). Bits [13:0] of a written base are discarded and act as zero.
- R4: A descriptor whose bits [1:0] are 2'b10 is a section. Its response, one cycle after `mem_rvalid`, carries `rsp_paddr` = {desc[31:20], vaddr[19:0]}, `rsp_cache` = desc[3] and `rsp_buffer` = desc[2].
- R5: The domain number is desc[8:5], and domain d uses bits [2d+1:2d] of the domain word. Codes 2'b01 and 2'b11 allow the access. Codes 2'b00 and 2'b10 abort it with `rsp_fsr` = {domain, 4'h9}, and paddr, cache and buffer all 0.
- R6: Any descriptor with bits [1:0] other than 2'b10 aborts with `rsp_fsr` = 8'h05 and is never cached, so a repeat access walks again.
- R7: `fault_addr` holds the virtual address of the most recent aborted access. Successful accesses leave it unchanged.
- R8: A cache hit responds in the cycle after acceptance with no memory read. Its domain check uses the domain word current at that time.
- R9: The cache has 4 entries, refilled in round-robin order. After an invalidate and misses on five distinct sections A..E, sections B..E hit and A walks.
- R10: A one-cycle `tlb_inv` pulse empties every entry, so the next access to any section walks.
- R11: If `tlb_inv` falls in the same cycle as `mem_rvalid`, the response is still delivered, but the descriptor is not kept.
- R12: `req_ready` is 1 when idle. It is 0 from the cycle after a miss is accepted up to the cycle in which `rsp_valid` is raised.
- R13: After reset, `req_ready` = 1, `rsp_valid` = 0, `mem_req` = 0, `fault_addr` = 0, and translation is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Settings write strobe |
| cfg_sel | input | 2 | Setting selector: 0 base, 1 domain word, 2 enable |
| cfg_wdata | input | 32 | Settings write data |
| tlb_inv | input | 1 | Invalidate all cached descriptors |
| req_valid | input | 1 | Translation request offered |
| req_ready | output | 1 | Request can be accepted |
| req_vaddr | input | 32 | Virtual address |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_paddr | output | 32 | Physical address (0 on abort) |
| rsp_cache | output | 1 | Region is cacheable |
| rsp_buffer | output | 1 | Region is bufferable |
| rsp_abort | output | 1 | Access aborted |
| rsp_fsr | output | 8 | Fault status: domain in [7:4], code in [3:0] |
| fault_addr | output | 32 | Virtual address of the last aborted access |
| mem_req | output | 1 | Descriptor read request, held until answered |
| mem_addr | output | 32 | Descriptor byte address |
| mem_rvalid | input | 1 | Descriptor data valid |
| mem_rdata | input | 32 | Descriptor word |

## Verification
Two events can land in the same clock edge: the completion of a table walk (`mem_rvalid`) and an invalidate-all. The bench provokes this by having its memory responder raise `tlb_inv` in the cycle it returns the descriptor. It first checks that the response still carries the correct translation. It then requests the same section again and expects a fresh memory read, because the fill must have been dropped. A control case without the overlap must hit instead.

// File: rtl/sect_xlate_pkg.sv
// Package: shared constants, the cached section record and the descriptor
// decoder for the section translation unit.
// Assumes 32-bit addresses, 1 MiB sections and 16 domains.
package sect_xlate_pkg;
    localparam int VA_W      = 32;
    localparam int SEC_LSB   = 20;
    localparam int IDX_W     = VA_W - SEC_LSB;
    localparam int TTB_ALIGN = IDX_W + 2;
    localparam int DOM_N     = 16;
    localparam int DOM_W     = $clog2(DOM_N);
    localparam int DOM_LSB   = 5;
    localparam int FSR_W     = DOM_W + 4;
    localparam int CFG_W     = 2;

    localparam logic [1:0] DESC_SECTION = 2'b10;
    localparam logic [3:0] FS_DOMAIN    = 4'h9;
    localparam logic [3:0] FS_XLATE     = 4'h5;

    localparam logic [CFG_W-1:0] SEL_BASE   = 2'd0;
    localparam logic [CFG_W-1:0] SEL_DOMAIN = 2'd1;
    localparam logic [CFG_W-1:0] SEL_ENABLE = 2'd2;

    typedef struct packed {
        logic [IDX_W-1:0] pa_hi;
        logic [DOM_W-1:0] dom;
        logic             cach;
        logic             buff;
    } sect_t;

    typedef enum logic {ST_IDLE, ST_WALK} walk_st_e;

    // Extract the fields of a section descriptor word
    function automatic sect_t decode_desc(input logic [VA_W-1:0] d);
        sect_t s;
        s.pa_hi = d[VA_W-1:SEC_LSB];
        s.dom   = d[DOM_LSB +: DOM_W];
        s.cach  = d[3];
        s.buff  = d[2];
        return s;
    endfunction
endpackage

// File: rtl/sx_cfg_regs.sv
// Settings holder: table base (aligned to the table size), domain access
// word and translation enable.
// Assumes one write per cycle; the low base bits are discarded on write.
module sx_cfg_regs
    import sect_xlate_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [CFG_W-1:0]   cfg_sel,
    input  logic [VA_W-1:0]    cfg_wdata,
    output logic [VA_W-1:0]    ttb,
    output logic [2*DOM_N-1:0] dacr,
    output logic               xlate_en
);
    // Capture the selected setting on a write strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ttb      <= '0;
            dacr     <= '0;
            xlate_en <= 1'b0;
        end else if (cfg_we) begin
            if (cfg_sel == SEL_BASE)
                ttb <= {cfg_wdata[VA_W-1:TTB_ALIGN], {TTB_ALIGN{1'b0}}};
            if (cfg_sel == SEL_DOMAIN)
                dacr <= cfg_wdata[2*DOM_N-1:0];
            if (cfg_sel == SEL_ENABLE)
                xlate_en <= cfg_wdata[0];
        end
    end
endmodule

// File: rtl/sx_tlb.sv
// Descriptor cache: fully associative, ENTRIES deep, round-robin refill.
// Invalidate-all takes priority over a fill issued in the same cycle, and
// the victim pointer only moves when a fill is really written.
// Assumes the caller never fills a tag that is already present.
module sx_tlb
    import sect_xlate_pkg::*;
#(
    parameter int ENTRIES = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               inv_all,
    input  logic [IDX_W-1:0]   look_tag,
    output logic               hit,
    output logic [ENTRIES-1:0] hit_vec,
    output sect_t              hit_data,
    input  logic               fill_en,
    input  logic [IDX_W-1:0]   fill_tag,
    input  sect_t              fill_data
);
    localparam int PTR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
    localparam logic [PTR_W-1:0] LAST = PTR_W'(ENTRIES - 1);

    logic [ENTRIES-1:0] valid_q;
    logic [IDX_W-1:0]   tag_q  [ENTRIES];
    sect_t              data_q [ENTRIES];
    logic [PTR_W-1:0]   victim_q;
    logic               do_fill;

    assign do_fill = fill_en && !inv_all;

    // Per-entry tag compare
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign hit_vec[g] = valid_q[g] && (tag_q[g] == look_tag);
    end

    assign hit = |hit_vec;

    // Select the hitting entry's record
    always_comb begin
        hit_data = '0;
        for (int i = 0; i < ENTRIES; i++)
            if (hit_vec[i]) hit_data = sect_t'(hit_data | data_q[i]);
    end

    // Valid bits and round-robin victim pointer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q  <= '0;
            victim_q <= '0;
        end else if (inv_all) begin
            valid_q <= '0;
        end else if (do_fill) begin
            valid_q[victim_q] <= 1'b1;
            victim_q <= (victim_q == LAST) ? '0 : victim_q + PTR_W'(1);
        end
    end

    // Entry payload write on fill
    always_ff @(posedge clk) begin
        if (do_fill) begin
            tag_q[victim_q]  <= fill_tag;
            data_q[victim_q] <= fill_data;
        end
    end
endmodule

// File: rtl/sx_domain_check.sv
// Domain and descriptor-type check: forms the physical address and
// attributes, or an abort with a packed fault status.
// Purely combinational; assumes the section record is already decoded.
module sx_domain_check
    import sect_xlate_pkg::*;
(
    input  logic [VA_W-1:0]    va,
    input  logic               is_sect,
    input  sect_t              sect,
    input  logic [2*DOM_N-1:0] dacr,
    output logic [VA_W-1:0]    pa,
    output logic               cach,
    output logic               buff,
    output logic               abort,
    output logic [FSR_W-1:0]   fsr
);
    logic [1:0] code;
    logic       allowed;

    assign code    = dacr[{sect.dom, 1'b0} +: 2];
    assign allowed = code[0];

    // Resolve translation result or fault
    always_comb begin
        pa    = '0;
        cach  = 1'b0;
        buff  = 1'b0;
        abort = 1'b1;
        fsr   = '0;
        if (!is_sect) begin
            fsr = {{DOM_W{1'b0}}, FS_XLATE};
        end else if (!allowed) begin
            fsr = {sect.dom, FS_DOMAIN};
        end else begin
            abort = 1'b0;
            pa    = {sect.pa_hi, va[SEC_LSB-1:0]};
            cach  = sect.cach;
            buff  = sect.buff;
        end
    end
endmodule

// File: rtl/sect_xlate_unit.sv
// Section translation unit top: accepts a request, looks it up in the
// descriptor cache, walks the table on a miss, checks the domain and
// returns a one-cycle response.
// Assumes the memory port answers every held read eventually; responses
// are not back-pressured.
module sect_xlate_unit
    import sect_xlate_pkg::*;
#(
    parameter int TLB_ENTRIES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [1:0]       cfg_sel,
    input  logic [31:0]      cfg_wdata,
    input  logic             tlb_inv,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [31:0]      req_vaddr,
    output logic             rsp_valid,
    output logic [31:0]      rsp_paddr,
    output logic             rsp_cache,
    output logic             rsp_buffer,
    output logic             rsp_abort,
    output logic [7:0]       rsp_fsr,
    output logic [31:0]      fault_addr,
    output logic             mem_req,
    output logic [31:0]      mem_addr,
    input  logic             mem_rvalid,
    input  logic [31:0]      mem_rdata
);
    logic [VA_W-1:0]        ttb;
    logic [2*DOM_N-1:0]     dacr;
    logic                   xlate_en;
    walk_st_e               state_q;
    logic [VA_W-1:0]        va_q;
    logic                   tlb_hit;
    logic [TLB_ENTRIES-1:0] tlb_hit_vec;
    sect_t                  tlb_hit_data;
    sect_t                  walk_sect;
    logic                   walk_is_sect;
    logic                   in_walk;
    logic                   accept;
    logic                   bypass;
    logic                   walk_done;
    logic                   take_result;
    logic [VA_W-1:0]        chk_va;
    sect_t                  chk_sect;
    logic                   chk_is_sect;
    logic [VA_W-1:0]        chk_pa;
    logic                   chk_cach;
    logic                   chk_buff;
    logic                   chk_abort;
    logic [FSR_W-1:0]       chk_fsr;

    sx_cfg_regs u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .ttb       (ttb),
        .dacr      (dacr),
        .xlate_en  (xlate_en)
    );

    assign in_walk      = (state_q == ST_WALK);
    assign req_ready    = !in_walk;
    assign accept       = req_valid && req_ready;
    assign bypass       = accept && !xlate_en;
    assign walk_done    = in_walk && mem_rvalid;
    assign take_result  = (accept && (!xlate_en || tlb_hit)) || walk_done;
    assign walk_sect    = decode_desc(mem_rdata);
    assign walk_is_sect = (mem_rdata[1:0] == DESC_SECTION);

    assign mem_req  = in_walk;
    assign mem_addr = {ttb[VA_W-1:TTB_ALIGN], va_q[VA_W-1:SEC_LSB], 2'b00};

    sx_tlb #(.ENTRIES(TLB_ENTRIES)) u_tlb (
        .clk       (clk),
        .rst_n     (rst_n),
        .inv_all   (tlb_inv),
        .look_tag  (req_vaddr[VA_W-1:SEC_LSB]),
        .hit       (tlb_hit),
        .hit_vec   (tlb_hit_vec),
        .hit_data  (tlb_hit_data),
        .fill_en   (walk_done && walk_is_sect),
        .fill_tag  (va_q[VA_W-1:SEC_LSB]),
        .fill_data (walk_sect)
    );

    // Checker input source: the walked descriptor while walking, else the cache hit
    always_comb begin
        if (in_walk) begin
            chk_va      = va_q;
            chk_sect    = walk_sect;
            chk_is_sect = walk_is_sect;
        end else begin
            chk_va      = req_vaddr;
            chk_sect    = tlb_hit_data;
            chk_is_sect = 1'b1;
        end
    end

    sx_domain_check u_chk (
        .va      (chk_va),
        .is_sect (chk_is_sect),
        .sect    (chk_sect),
        .dacr    (dacr),
        .pa      (chk_pa),
        .cach    (chk_cach),
        .buff    (chk_buff),
        .abort   (chk_abort),
        .fsr     (chk_fsr)
    );

    // Walk state machine and latched request address
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            va_q    <= '0;
        end else if (in_walk) begin
            if (mem_rvalid) state_q <= ST_IDLE;
        end else if (accept && xlate_en && !tlb_hit) begin
            state_q <= ST_WALK;
            va_q    <= req_vaddr;
        end
    end

    // Response register: one-cycle pulse with the resolved result
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid  <= 1'b0;
            rsp_paddr  <= '0;
            rsp_cache  <= 1'b0;
            rsp_buffer <= 1'b0;
            rsp_abort  <= 1'b0;
            rsp_fsr    <= '0;
        end else begin
            rsp_valid <= take_result;
            if (bypass) begin
                rsp_paddr  <= req_vaddr;
                rsp_cache  <= 1'b0;
                rsp_buffer <= 1'b0;
                rsp_abort  <= 1'b0;
                rsp_fsr    <= '0;
            end else if (take_result) begin
                rsp_paddr  <= chk_pa;
                rsp_cache  <= chk_cach;
                rsp_buffer <= chk_buff;
                rsp_abort  <= chk_abort;
                rsp_fsr    <= chk_fsr;
            end
        end
    end

    // Fault address register: capture the address of each aborted access
    always_ff @(posedge clk) begin
        if (!rst_n)
            fault_addr <= '0;
        else if (take_result && !bypass && chk_abort)
            fault_addr <= chk_va;
    end
endmodule

// File: rtl/sx_checker.sv
// Property checker for the section translation unit, bound to the top.
// Observes ports plus the enable and cache hit vector.
module sx_checker #(
    parameter int ENTRIES = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req_valid,
    input logic               req_ready,
    input logic [31:0]        req_vaddr,
    input logic               rsp_valid,
    input logic [31:0]        rsp_paddr,
    input logic               rsp_cache,
    input logic               rsp_buffer,
    input logic               rsp_abort,
    input logic [7:0]         rsp_fsr,
    input logic               mem_req,
    input logic [31:0]        mem_addr,
    input logic               mem_rvalid,
    input logic               xlate_en,
    input logic [ENTRIES-1:0] hit_vec
);
    a_r12_busy_while_walking: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !req_ready);

    a_r2_read_held: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_rvalid) |=> (mem_req && $stable(mem_addr)));

    a_r2_word_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr[1:0] == 2'b00));

    a_r1_bypass_identity: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !xlate_en) |=>
            (rsp_valid && !rsp_abort && rsp_paddr == $past(req_vaddr)));

    a_r5_abort_clean: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_abort) |->
            (rsp_paddr == 32'h0 && !rsp_cache && !rsp_buffer &&
             (rsp_fsr[3:0] == 4'h9 || rsp_fsr == 8'h05)));

    a_r9_single_hit: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));

    a_r12_walk_answers: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_rvalid) |=> (rsp_valid && req_ready));
endmodule

bind sect_xlate_unit sx_checker #(.ENTRIES(TLB_ENTRIES)) u_sx_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_vaddr  (req_vaddr),
    .rsp_valid  (rsp_valid),
    .rsp_paddr  (rsp_paddr),
    .rsp_cache  (rsp_cache),
    .rsp_buffer (rsp_buffer),
    .rsp_abort  (rsp_abort),
    .rsp_fsr    (rsp_fsr),
    .mem_req    (mem_req),
    .mem_addr   (mem_addr),
    .mem_rvalid (mem_rvalid),
    .xlate_en   (xlate_en),
    .hit_vec    (tlb_hit_vec)
);

// File: tb/sect_xlate_unit_test.sv
`timescale 1ns/1ps
// Bench: directed corner cases plus seeded random traffic, checked against
// expected values computed from the requirements.
module sect_xlate_unit_test;
    typedef struct packed {
        logic [31:0] pa;
        logic        c;
        logic        b;
        logic        ab;
        logic [7:0]  fsr;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = 2'd0;
    logic [31:0] cfg_wdata = 32'h0;
    logic        tlb_inv = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = 32'h0;
    logic        rsp_valid;
    logic [31:0] rsp_paddr;
    logic        rsp_cache;
    logic        rsp_buffer;
    logic        rsp_abort;
    logic [7:0]  rsp_fsr;
    logic [31:0] fault_addr;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = 32'h0;

    int checks = 0;
    int fails = 0;
    int mem_reads = 0;
    int lat = 0;
    bit inv_on_rv = 1'b0;
    bit inv_by_resp = 1'b0;
    logic [31:0] ttb_model = 32'h0;
    logic [31:0] dacr_model = 32'h0;
    logic        en_model = 1'b0;
    logic [31:0] far_model = 32'h0;
    logic [11:0] cur_idx = 12'h0;
    logic [31:0] ovr [int];

    always #4 clk = ~clk;

    sect_xlate_unit uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .tlb_inv(tlb_inv), .req_valid(req_valid),
        .req_ready(req_ready), .req_vaddr(req_vaddr), .rsp_valid(rsp_valid),
        .rsp_paddr(rsp_paddr), .rsp_cache(rsp_cache), .rsp_buffer(rsp_buffer),
        .rsp_abort(rsp_abort), .rsp_fsr(rsp_fsr), .fault_addr(fault_addr),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
        .mem_rdata(mem_rdata)
    );

    task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    function automatic logic [31:0] desc_at(input logic [11:0] idx);
        if (ovr.exists(int'(idx))) return ovr[int'(idx)];
        return {idx ^ 12'hA5C, 11'b0, idx[3:0], 1'b0, idx[4], idx[5], 2'b10};
    endfunction

    function automatic exp_t exp_of(input logic [31:0] va);
        exp_t e;
        logic [31:0] d;
        logic [3:0] dom;
        logic [1:0] code;
        e = '0;
        if (!en_model) begin
            e.pa = va;
            return e;
        end
        d = desc_at(va[31:20]);
        dom = d[8:5];
        code = dacr_model[2*dom +: 2];
        if (d[1:0] != 2'b10) begin
            e.ab = 1'b1; e.fsr = 8'h05;
        end else if (code == 2'b00 || code == 2'b10) begin
            e.ab = 1'b1; e.fsr = {dom, 4'h9};
        end else begin
            e.pa = {d[31:20], va[19:0]}; e.c = d[3]; e.b = d[2];
        end
        return e;
    endfunction

    // Memory responder: random latency, checks the descriptor address (R2, R3)
    initial begin
        forever begin
            @(negedge clk);
            if (inv_by_resp) begin
                tlb_inv = 1'b0;
                inv_by_resp = 1'b0;
            end
            if (mem_rvalid) begin
                mem_rvalid = 1'b0;
            end else if (mem_req) begin
                if (lat == 0) begin
                    chk(mem_addr == {ttb_model[31:14], cur_idx, 2'b00}, "R2/R3 descriptor address",
                        64'(mem_addr), 64'({ttb_model[31:14], cur_idx, 2'b00}));
                    mem_rdata  = desc_at(mem_addr[13:2]);
                    mem_rvalid = 1'b1;
                    mem_reads++;
                    lat = int'($urandom % 3);
                    if (inv_on_rv) begin
                        tlb_inv = 1'b1;
                        inv_by_resp = 1'b1;
                    end
                end else begin
                    lat--;
                end
            end
        end
    end

    task automatic cfg_write(input logic [1:0] sel, input logic [31:0] data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0;
        if (sel == 2'd0) ttb_model = data & 32'hFFFF_C000;
        if (sel == 2'd1) dacr_model = data;
        if (sel == 2'd2) en_model = data[0];
    endtask

    task automatic invalidate();
        @(negedge clk);
        tlb_inv = 1'b1;
        @(negedge clk);
        tlb_inv = 1'b0;
    endtask

    task automatic xlate(input logic [31:0] va, output exp_t got, output int cyc, output int reads);
        int r0;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        cur_idx = va[31:20];
        r0 = mem_reads;
        req_valid = 1'b1; req_vaddr = va;
        @(negedge clk);
        req_valid = 1'b0;
        cyc = 1;
        while (!rsp_valid && cyc < 60) begin
            chk(req_ready == 1'b0, "R12 ready low during walk", 64'(req_ready), 64'd0);
            @(negedge clk);
            cyc++;
        end
        chk(req_ready == 1'b1, "R12 ready back at response", 64'(req_ready), 64'd1);
        got = {rsp_paddr, rsp_cache, rsp_buffer, rsp_abort, rsp_fsr};
        reads = mem_reads - r0;
    endtask

    // want_walk: 0 expect hit, 1 expect one read, -1 either
    task automatic run(input logic [31:0] va, input int want_walk, input string rq);
        exp_t e, g;
        int cyc, rd;
        e = exp_of(va);
        xlate(va, g, cyc, rd);
        chk(g == e, rq, 64'(g), 64'(e));
        if (want_walk == 0)
            chk(rd == 0 && cyc == 1, {rq, " hit timing"}, 64'(rd * 256 + cyc), 64'd1);
        else if (want_walk == 1)
            chk(rd == 1, {rq, " single walk"}, 64'(rd), 64'd1);
        if (e.ab) far_model = va;
        chk(fault_addr == far_model, "R7 fault address", 64'(fault_addr), 64'(far_model));
    endtask

    task automatic finish_up();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    endtask

    initial begin
        #(8 * 150000);
        checks++; fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_up();
    end

    function automatic logic [31:0] set_dom(input logic [31:0] w, input int d, input logic [1:0] c);
        logic [31:0] r;
        r = w;
        r[2*d +: 2] = c;
        return r;
    endfunction

    initial begin
        logic [31:0] base_dacr;
        void'($urandom(32'd7541));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R13 reset state
        chk(req_ready == 1'b1, "R13 ready", 64'(req_ready), 64'd1);
        chk(rsp_valid == 1'b0, "R13 rsp_valid", 64'(rsp_valid), 64'd0);
        chk(mem_req == 1'b0, "R13 mem_req", 64'(mem_req), 64'd0);
        chk(fault_addr == 32'h0, "R13 fault_addr", 64'(fault_addr), 64'd0);

        // R1 bypass while disabled (also R13: enable is clear after reset)
        run(32'h1234_5678, 0, "R1 bypass");
        run(32'hFFFF_FFFC, 0, "R1 bypass top");
        run(32'h0010_0001, 0, "R1 bypass low");

        // R3 base low bits discarded; domain word setup
        cfg_write(2'd0, 32'h1234_5ABC);
        base_dacr = 32'hFFFF_FFFF;
        base_dacr = set_dom(base_dacr, 1, 2'b00);
        base_dacr = set_dom(base_dacr, 2, 2'b10);
        base_dacr = set_dom(base_dacr, 3, 2'b01);
        cfg_write(2'd1, base_dacr);
        cfg_write(2'd2, 32'h1);
        invalidate();

        // R2, R4 walk then R8 hit
        run(32'h0030_1234, 1, "R4 section walk");
        run(32'h003F_FFFF, 0, "R8 same section hit");
        run(32'h0230_0040, 1, "R4 cache/buffer attrs");

        // R5 domain faults and R7 persistence
        run(32'h0010_0ABC, 1, "R5 domain code 00");
        run(32'h0020_0004, 1, "R5 domain code 10");
        run(32'h0000_0100, 1, "R7 success keeps fault addr");

        // R8 current domain word applies to a cached entry
        run(32'h0140_0000, 1, "R8 fill dom4");
        cfg_write(2'd1, set_dom(base_dacr, 4, 2'b00));
        run(32'h0140_0010, 0, "R8 hit sees new domain word");
        cfg_write(2'd1, base_dacr);

        // R6 non-section descriptors are faults and are not cached
        ovr[12'h050] = 32'h0000_0000;
        ovr[12'h061] = 32'hABC0_0021;
        invalidate();
        run(32'h0500_0000, 1, "R6 type 00");
        run(32'h0500_0004, 1, "R6 not cached");
        run(32'h0610_0000, 1, "R6 type 01");

        // R9 round-robin refill
        invalidate();
        run(32'h1000_0000, 1, "R9 fill A");
        run(32'h1030_0000, 1, "R9 fill B");
        run(32'h1050_0000, 1, "R9 fill C");
        run(32'h1060_0000, 1, "R9 fill D");
        run(32'h1070_0000, 1, "R9 fill E");
        run(32'h1030_0004, 0, "R9 B kept");
        run(32'h1050_0004, 0, "R9 C kept");
        run(32'h1060_0004, 0, "R9 D kept");
        run(32'h1070_0004, 0, "R9 E kept");
        run(32'h1000_0004, 1, "R9 A evicted");

        // R10 invalidate-all
        invalidate();
        run(32'h1030_0008, 1, "R10 walk after invalidate");

        // R11 invalidate coinciding with walk completion
        inv_on_rv = 1'b1;
        run(32'h2000_0000, 1, "R11 response kept");
        inv_on_rv = 1'b0;
        run(32'h2000_0010, 1, "R11 fill dropped");
        run(32'h2080_0000, 1, "R11 control fill");
        run(32'h2080_0010, 0, "R11 control hit");

        // Random traffic mixing R4, R5, R6, R1 with table edits and invalidates
        for (int n = 0; n < 300; n++) begin
            logic [11:0] idx;
            int pick;
            pick = int'($urandom % 32);
            if (pick == 0) cfg_write(2'd1, $urandom);
            else if (pick == 1) cfg_write(2'd2, {31'b0, ($urandom % 4) != 0});
            else if (pick == 2) begin
                idx = {($urandom % 2) ? 4'h3 : 4'h0, 4'h0, 4'($urandom)};
                ovr[int'(idx)] = $urandom;
                invalidate();
            end else if (pick == 3) invalidate();
            idx = {($urandom % 2) ? 4'h3 : 4'h0, 4'h0, 4'($urandom)};
            run({idx, 20'($urandom)}, -1, "R4/R5 random");
        end
        finish_up();
    end
endmodule